// File: doc/BRIEF.md
# Nonvolatile Store Sequencer with Ready Flag

This block runs the slow commands that move settings between a small byte store and the live control registers of a four-channel digitally set resistor. The store is 16 bytes. Entries 0 to 3 hold the four wiper settings. Entry 4 holds the two latched digital outputs in its bits 0 and 1. Entries 5 to 15 are free user bytes. The store is modelled with flip-flops, so it is reset together with the rest of the logic.

A command is presented on `cmd_i`, `addr_i` and `wdata_i` and is taken by a one-cycle `exec_i` pulse while `rdy_o` is high. Save, store-data, reload-all and both read commands are slow. Each drops `rdy_o` for its own parameterised number of clock cycles. The effect on the store or on the live registers lands on the clock edge at which `rdy_o` returns high. A single-entry recall is fast and completes at once. After reset the block runs a reload-all by itself, so the live wipers and outputs come up from the store. The write-protect input blocks changes to the store but does not change any timing.

Top module: `nv_store_seq`

## Requirements
- R1: During reset the store holds 0x80 in entries 0..3 and 0x00 in entries 4..15, the live wipers and outputs are 0 and `rdy_o` is low. After reset is released, `rdy_o` stays low for exactly RELOAD_CYC cycles, then rises, and at that point the wipers equal entries 0..3 and `dout_o` equals entry 4 bits [1:0].
- R2: Code 3 (store-data) writes `wdata_i` into the entry selected by `addr_i` (any of 0..15).
- R3: Code 2 (save) copies live wiper n into entry n for addr 0..3. For addr 4 it writes `{6'b0, dout_o}`. For addr 5..15 it leaves the store unchanged.
- R4: Code 1 (recall) loads entry n into wiper n (addr 0..3), or entry 4 bits [1:0] into `dout_o` (addr 4). The load happens on the accepting edge and `rdy_o` stays high.
- R5: Code 8 (reload all) keeps `rdy_o` low for RELOAD_CYC cycles and then loads all wipers and `dout_o` from the store.
- R6: Code 9 returns the store entry at `addr_i` on `rdata_o`. Code 10 returns live wiper n (addr 0..3), `{6'b0, dout_o}` (addr 4) or 0 (addr 5..15). Both keep `rdy_o` low for READ_CYC cycles, and `rdata_o` is valid once `rdy_o` is high again.
- R7: Codes 2 and 3 keep `rdy_o` low for exactly SAVE_CYC cycles, counted from the cycle after the accepting edge.
- R8: An `exec_i` pulse while `rdy_o` is low is ignored. It does not restart or lengthen the busy time, and it does not change the command in progress.
- R9: While `wp_n_i` is low when the command is accepted, codes 2 and 3 leave the store unchanged, but `rdy_o` still drops for SAVE_CYC cycles.
- R10: Codes 0, 4 to 7 and 11 to 15 are ignored. `rdy_o` stays high and the wipers and outputs do not change.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| exec_i | input | 1 | One-cycle command execute pulse |
| cmd_i | input | 4 | Command code |
| addr_i | input | 4 | Store entry / channel address |
| wdata_i | input | 8 | Data byte for store-data |
| wp_n_i | input | 1 | Write protect, active low |
| rdy_o | output | 1 | High when idle, low while a slow command runs |
| rdata_o | output | 8 | Readback byte of codes 9 and 10 |
| wiper_o | output | 32 | Live wipers, wiper n at bits [8n+7:8n] |
| dout_o | output | 2 | Live latched digital outputs |

## Verification
The bench drives `exec_i` on a falling edge, so the command is taken on the next rising edge. From the following falling edge it counts the falling edges at which `rdy_o` is still low. That count must equal the busy time of the command class exactly: SAVE_CYC, RELOAD_CYC or READ_CYC, and RELOAD_CYC after reset release. A recall or an ignored code must instead show `rdy_o` high and the new or unchanged register values one falling edge after the pulse. Store contents are checked only through a later code-9 read, after its own busy time has ended. For the busy-lockout case, the falling edges before, during and after the second pulse are added up, and the sum must still be SAVE_CYC.

// File: rtl/nvs_pkg.sv
// Package: command codes shared by the store sequencer modules.
// Assumes 4-bit command codes; codes not listed here are ignored.
package nvs_pkg;
    localparam logic [3:0] CMD_RECALL = 4'd1;
    localparam logic [3:0] CMD_SAVE   = 4'd2;
    localparam logic [3:0] CMD_STORE  = 4'd3;
    localparam logic [3:0] CMD_RELOAD = 4'd8;
    localparam logic [3:0] CMD_RDMEM  = 4'd9;
    localparam logic [3:0] CMD_RDLIVE = 4'd10;
endpackage

// File: rtl/nvs_timer.sv
// Busy timer: holds rdy_o low for dur_i cycles after a start pulse that is
// taken only while ready. Out of reset it runs a BOOT_CYC busy period.
// done_o marks the last busy cycle; effects are applied on that edge.
module nvs_timer #(
    parameter int CNT_W    = 8,
    parameter int BOOT_CYC = 12
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             start_i,
    input  logic [CNT_W-1:0] dur_i,
    output logic             rdy_o,
    output logic             done_o
);
    logic [CNT_W-1:0] cnt_q;

    // Count down the busy window; a start while busy is not seen.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            cnt_q <= CNT_W'(BOOT_CYC - 1);
            rdy_o <= 1'b0;
        end else if (rdy_o && start_i) begin
            cnt_q <= dur_i - 1'b1;
            rdy_o <= 1'b0;
        end else if (!rdy_o) begin
            if (cnt_q == '0) rdy_o <= 1'b1;
            else             cnt_q <= cnt_q - 1'b1;
        end
    end

    // Last busy cycle.
    always_comb done_o = !rdy_o && (cnt_q == '0);

    // R7: ready can only come back when the count has run out
    p_rdy_rise_at_zero_r7: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(rdy_o) |-> $past(cnt_q) == '0);
    // R7: a nonzero count keeps the flag low
    p_busy_holds_r7: assert property (@(posedge clk) disable iff (!rst_n)
        (!rdy_o && cnt_q != '0) |=> !rdy_o);
    // R8: a start while busy never restarts the count
    p_no_restart_r8: assert property (@(posedge clk) disable iff (!rst_n)
        (!rdy_o && cnt_q != '0) |=> cnt_q == $past(cnt_q) - 1'b1);
endmodule

// File: rtl/nvs_array.sv
// Flop model of the byte store with one write port. Entries below N_WIPER
// come out of reset at midscale; all others at zero.
module nvs_array #(
    parameter int DATA_W  = 8,
    parameter int ADDR_W  = 4,
    parameter int N_WIPER = 4,
    localparam int DEPTH  = 1 << ADDR_W
) (
    input  logic                    clk,
    input  logic                    rst_n,
    input  logic                    we_i,
    input  logic [ADDR_W-1:0]       waddr_i,
    input  logic [DATA_W-1:0]       wdata_i,
    output logic [DEPTH*DATA_W-1:0] mem_o
);
    localparam logic [DATA_W-1:0] MID = DATA_W'(1) << (DATA_W - 1);

    for (genvar e = 0; e < DEPTH; e++) begin : g_ent
        localparam logic [DATA_W-1:0] RST_VAL = (e < N_WIPER) ? MID : '0;
        // Hold one entry; write when selected.
        always_ff @(posedge clk) begin
            if (!rst_n)
                mem_o[e*DATA_W +: DATA_W] <= RST_VAL;
            else if (we_i && waddr_i == ADDR_W'(e))
                mem_o[e*DATA_W +: DATA_W] <= wdata_i;
        end
    end

    // R1/R9: without a write strobe the store does not move
    p_store_hold_r9: assert property (@(posedge clk) disable iff (!rst_n)
        !we_i |=> $stable(mem_o));
endmodule

// File: rtl/nvs_live.sv
// Live wiper and digital-output registers, loaded from the store either
// all at once or one entry at a time. Entry N_WIPER feeds the outputs.
module nvs_live #(
    parameter int DATA_W  = 8,
    parameter int ADDR_W  = 4,
    parameter int N_WIPER = 4,
    parameter int N_OUT   = 2,
    localparam int DEPTH  = 1 << ADDR_W
) (
    input  logic                      clk,
    input  logic                      rst_n,
    input  logic                      ld_all_i,
    input  logic                      ld_one_i,
    input  logic [ADDR_W-1:0]         ld_idx_i,
    input  logic [DEPTH*DATA_W-1:0]   mem_i,
    output logic [N_WIPER*DATA_W-1:0] wiper_o,
    output logic [N_OUT-1:0]          dout_o
);
    for (genvar w = 0; w < N_WIPER; w++) begin : g_wip
        // Load one wiper from its store entry.
        always_ff @(posedge clk) begin
            if (!rst_n)
                wiper_o[w*DATA_W +: DATA_W] <= '0;
            else if (ld_all_i || (ld_one_i && ld_idx_i == ADDR_W'(w)))
                wiper_o[w*DATA_W +: DATA_W] <= mem_i[w*DATA_W +: DATA_W];
        end
    end

    // Load the latched outputs from the low bits of their entry.
    always_ff @(posedge clk) begin
        if (!rst_n)
            dout_o <= '0;
        else if (ld_all_i || (ld_one_i && ld_idx_i == ADDR_W'(N_WIPER)))
            dout_o <= mem_i[N_WIPER*DATA_W +: N_OUT];
    end

    // R4/R10: with no load strobe the live registers hold
    p_live_hold_r10: assert property (@(posedge clk) disable iff (!rst_n)
        (!ld_all_i && !ld_one_i) |=> ($stable(wiper_o) && $stable(dout_o)));
endmodule

// File: rtl/nv_store_seq.sv
// Top: decodes commands, latches the slow command, runs the busy timer and
// applies the store or live-register effect when the timer expires.
// Assumes exec_i is a single-cycle pulse; pulses while busy are dropped.
module nv_store_seq #(
    parameter int DATA_W     = 8,
    parameter int ADDR_W     = 4,
    parameter int N_WIPER    = 4,
    parameter int N_OUT      = 2,
    parameter int SAVE_CYC   = 40,
    parameter int RELOAD_CYC = 12,
    parameter int READ_CYC   = 6,
    localparam int DEPTH     = 1 << ADDR_W,
    localparam int MAX_CYC   = (SAVE_CYC > RELOAD_CYC) ?
                               ((SAVE_CYC > READ_CYC) ? SAVE_CYC : READ_CYC) :
                               ((RELOAD_CYC > READ_CYC) ? RELOAD_CYC : READ_CYC),
    localparam int CNT_W     = $clog2(MAX_CYC + 1)
) (
    input  logic                      clk,
    input  logic                      rst_n,
    input  logic                      exec_i,
    input  logic [3:0]                cmd_i,
    input  logic [ADDR_W-1:0]         addr_i,
    input  logic [DATA_W-1:0]         wdata_i,
    input  logic                      wp_n_i,
    output logic                      rdy_o,
    output logic [DATA_W-1:0]         rdata_o,
    output logic [N_WIPER*DATA_W-1:0] wiper_o,
    output logic [N_OUT-1:0]          dout_o
);
    import nvs_pkg::*;

    logic                    accept, is_slow, is_known, start, done;
    logic [CNT_W-1:0]        dur;
    logic [3:0]              op_q;
    logic [ADDR_W-1:0]       addr_q;
    logic [DATA_W-1:0]       data_q;
    logic                    wpn_q;
    logic [DEPTH*DATA_W-1:0] mem;
    logic [DATA_W-1:0]       mem_byte, live_byte, save_byte, wr_byte;
    logic                    we, ld_all, ld_one;

    // Decode the presented command and pick its busy time.
    always_comb begin
        accept   = exec_i && rdy_o;
        is_slow  = (cmd_i == CMD_SAVE) || (cmd_i == CMD_STORE) ||
                   (cmd_i == CMD_RELOAD) || (cmd_i == CMD_RDMEM) ||
                   (cmd_i == CMD_RDLIVE);
        is_known = is_slow || (cmd_i == CMD_RECALL);
        start    = accept && is_slow;
        if (cmd_i == CMD_SAVE || cmd_i == CMD_STORE) dur = CNT_W'(SAVE_CYC);
        else if (cmd_i == CMD_RELOAD)                dur = CNT_W'(RELOAD_CYC);
        else                                         dur = CNT_W'(READ_CYC);
    end

    // Select the store byte and the live byte at the presented address.
    always_comb begin
        mem_byte  = '0;
        live_byte = '0;
        for (int e = 0; e < DEPTH; e++)
            if (addr_i == ADDR_W'(e)) mem_byte = mem[e*DATA_W +: DATA_W];
        for (int w = 0; w < N_WIPER; w++)
            if (addr_i == ADDR_W'(w)) live_byte = wiper_o[w*DATA_W +: DATA_W];
        if (addr_i == ADDR_W'(N_WIPER)) live_byte = DATA_W'(dout_o);
    end

    // Select the live byte that a save at the latched address writes.
    always_comb begin
        save_byte = '0;
        for (int w = 0; w < N_WIPER; w++)
            if (addr_q == ADDR_W'(w)) save_byte = wiper_o[w*DATA_W +: DATA_W];
        if (addr_q == ADDR_W'(N_WIPER)) save_byte = DATA_W'(dout_o);
    end

    // Latch the slow command; reset leaves a reload pending for power-up.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            op_q   <= CMD_RELOAD;
            addr_q <= '0;
            data_q <= '0;
            wpn_q  <= 1'b1;
        end else if (start) begin
            op_q   <= cmd_i;
            addr_q <= addr_i;
            data_q <= wdata_i;
            wpn_q  <= wp_n_i;
        end
    end

    // Capture the readback byte when a read command is taken.
    always_ff @(posedge clk) begin
        if (!rst_n)
            rdata_o <= '0;
        else if (accept && cmd_i == CMD_RDMEM)
            rdata_o <= mem_byte;
        else if (accept && cmd_i == CMD_RDLIVE)
            rdata_o <= live_byte;
    end

    // Effects at completion (store, reload) or at accept (recall).
    always_comb begin
        we      = done && wpn_q &&
                  ((op_q == CMD_STORE) ||
                   (op_q == CMD_SAVE && addr_q <= ADDR_W'(N_WIPER)));
        wr_byte = (op_q == CMD_STORE) ? data_q : save_byte;
        ld_all  = done && (op_q == CMD_RELOAD);
        ld_one  = accept && (cmd_i == CMD_RECALL);
    end

    nvs_timer #(.CNT_W(CNT_W), .BOOT_CYC(RELOAD_CYC)) i_timer (
        .clk(clk), .rst_n(rst_n), .start_i(start), .dur_i(dur),
        .rdy_o(rdy_o), .done_o(done)
    );

    nvs_array #(.DATA_W(DATA_W), .ADDR_W(ADDR_W), .N_WIPER(N_WIPER)) i_array (
        .clk(clk), .rst_n(rst_n), .we_i(we), .waddr_i(addr_q),
        .wdata_i(wr_byte), .mem_o(mem)
    );

    nvs_live #(.DATA_W(DATA_W), .ADDR_W(ADDR_W), .N_WIPER(N_WIPER),
               .N_OUT(N_OUT)) i_live (
        .clk(clk), .rst_n(rst_n), .ld_all_i(ld_all), .ld_one_i(ld_one),
        .ld_idx_i(addr_i), .mem_i(mem), .wiper_o(wiper_o), .dout_o(dout_o)
    );

    // R4: a recall never drops the ready flag
    p_recall_fast_r4: assert property (@(posedge clk) disable iff (!rst_n)
        (exec_i && rdy_o && cmd_i == CMD_RECALL) |=> rdy_o);
    // R8: a pulse while busy leaves the latched command alone
    p_busy_ignore_r8: assert property (@(posedge clk) disable iff (!rst_n)
        (exec_i && !rdy_o) |=> ($stable(op_q) && $stable(addr_q) && $stable(data_q)));
    // R9: a protected command never changes the store
    p_wp_hold_r9: assert property (@(posedge clk) disable iff (!rst_n)
        (!rdy_o && !wpn_q) |=> $stable(mem));
    // R10: unknown codes keep ready and the live registers
    p_unknown_r10: assert property (@(posedge clk) disable iff (!rst_n)
        (exec_i && rdy_o && !is_known) |=> (rdy_o && $stable(wiper_o) && $stable(dout_o)));
    // R7: a slow command drops ready on the next cycle
    p_slow_drops_r7: assert property (@(posedge clk) disable iff (!rst_n)
        (exec_i && rdy_o && is_slow) |=> !rdy_o);
endmodule

// File: tb/test_nv_store_seq.sv
// Directed bench for the store sequencer: one task per scenario.
module test_nv_store_seq;
    localparam int CLK_PERIOD = 10;
    localparam int SAVE_CYC   = 40;
    localparam int RELOAD_CYC = 12;
    localparam int READ_CYC   = 6;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        exec_i = 1'b0;
    logic [3:0]  cmd_i = '0;
    logic [3:0]  addr_i = '0;
    logic [7:0]  wdata_i = '0;
    logic        wp_n_i = 1'b1;
    logic        rdy_o;
    logic [7:0]  rdata_o;
    logic [31:0] wiper_o;
    logic [1:0]  dout_o;

    int n_chk = 0;
    int n_bad = 0;

    always #(CLK_PERIOD / 2) clk = ~clk;

    nv_store_seq #(.SAVE_CYC(SAVE_CYC), .RELOAD_CYC(RELOAD_CYC),
                   .READ_CYC(READ_CYC)) i_nv_store_seq (
        .clk(clk), .rst_n(rst_n), .exec_i(exec_i), .cmd_i(cmd_i),
        .addr_i(addr_i), .wdata_i(wdata_i), .wp_n_i(wp_n_i), .rdy_o(rdy_o),
        .rdata_o(rdata_o), .wiper_o(wiper_o), .dout_o(dout_o)
    );

    task automatic chk(input bit ok, input string req, input int act, input int exp);
        n_chk++;
        if (!ok) begin
            n_bad++;
            $display("FAIL %s: actual 0x%0h expected 0x%0h", req, act, exp);
        end
    endtask

    function automatic int wip(input int n);
        return int'(wiper_o[n*8 +: 8]);
    endfunction

    // Drive a command at the current falling edge; return one edge later.
    task automatic issue(input int cmd, input int addr, input int data);
        exec_i  = 1'b1;
        cmd_i   = 4'(cmd);
        addr_i  = 4'(addr);
        wdata_i = 8'(data);
        @(negedge clk);
        exec_i  = 1'b0;
    endtask

    // Count falling edges with ready low, starting at the current one.
    task automatic busy_len(output int n);
        n = 0;
        while (!rdy_o) begin
            n++;
            @(negedge clk);
        end
    endtask

    task automatic read_mem(input int addr, input int exp, input string req);
        int n;
        issue(9, addr, 0);
        busy_len(n);
        chk(n == READ_CYC, "R6 read busy", n, READ_CYC);
        chk(rdata_o == 8'(exp), req, rdata_o, exp);
    endtask

    task automatic t_reset_boot();
        int n;
        repeat (3) @(negedge clk);
        chk(rdy_o == 1'b0, "R1 rdy in reset", rdy_o, 0);
        chk(wiper_o == '0, "R1 wipers in reset", wiper_o, 0);
        rst_n = 1'b1;
        busy_len(n);
        chk(n == RELOAD_CYC, "R1 boot busy", n, RELOAD_CYC);
        for (int w = 0; w < 4; w++)
            chk(wip(w) == 8'h80, "R1 boot wiper", wip(w), 8'h80);
        chk(dout_o == 2'b00, "R1 boot outputs", dout_o, 0);
    endtask

    task automatic t_unknown();
        issue(4, 0, 8'h12);
        chk(rdy_o == 1'b1, "R10 code 4 rdy", rdy_o, 1);
        chk(wip(0) == 8'h80, "R10 code 4 wiper", wip(0), 8'h80);
        issue(0, 1, 8'h12);
        issue(15, 2, 8'h12);
        chk(rdy_o == 1'b1, "R10 code 15 rdy", rdy_o, 1);
        chk(wiper_o == 32'h80808080, "R10 wipers", wiper_o, 32'h80808080);
    endtask

    task automatic t_store_read();
        int n;
        issue(3, 7, 8'hA5);
        busy_len(n);
        chk(n == SAVE_CYC, "R7 store busy", n, SAVE_CYC);
        read_mem(7, 8'hA5, "R2 store then read");
    endtask

    task automatic t_recall();
        int n;
        issue(3, 1, 8'h3C);
        busy_len(n);
        issue(1, 1, 0);
        chk(rdy_o == 1'b1, "R4 recall rdy", rdy_o, 1);
        chk(wip(1) == 8'h3C, "R4 recall wiper1", wip(1), 8'h3C);
        chk(wip(0) == 8'h80, "R4 recall wiper0 kept", wip(0), 8'h80);
    endtask

    task automatic t_save();
        int n;
        issue(3, 1, 8'h11);
        busy_len(n);
        issue(2, 1, 0);
        busy_len(n);
        chk(n == SAVE_CYC, "R7 save busy", n, SAVE_CYC);
        read_mem(1, 8'h3C, "R3 save wiper1");
        issue(10, 1, 0);
        busy_len(n);
        chk(n == READ_CYC, "R6 live read busy", n, READ_CYC);
        chk(rdata_o == 8'h3C, "R6 live read", rdata_o, 8'h3C);
    endtask

    task automatic t_reload();
        int n;
        issue(3, 4, 8'h03);
        busy_len(n);
        issue(3, 2, 8'h44);
        busy_len(n);
        issue(8, 0, 0);
        busy_len(n);
        chk(n == RELOAD_CYC, "R5 reload busy", n, RELOAD_CYC);
        chk(dout_o == 2'b11, "R5 reload outputs", dout_o, 3);
        chk(wip(2) == 8'h44, "R5 reload wiper2", wip(2), 8'h44);
        chk(wip(3) == 8'h80, "R5 reload wiper3", wip(3), 8'h80);
        issue(3, 4, 8'h00);
        busy_len(n);
        issue(2, 4, 0);
        busy_len(n);
        read_mem(4, 8'h03, "R3 save outputs");
        issue(10, 4, 0);
        busy_len(n);
        chk(rdata_o == 8'h03, "R6 live read outputs", rdata_o, 3);
    endtask

    task automatic t_protect();
        int n;
        wp_n_i = 1'b0;
        issue(3, 7, 8'h5A);
        busy_len(n);
        chk(n == SAVE_CYC, "R9 protected busy", n, SAVE_CYC);
        read_mem(7, 8'hA5, "R9 protected store");
        wp_n_i = 1'b1;
    endtask

    task automatic t_busy_ignore();
        int n, m;
        issue(3, 8, 8'h77);
        n = 0;
        repeat (3) begin
            if (!rdy_o) n++;
            @(negedge clk);
        end
        if (!rdy_o) n++;
        issue(3, 8, 8'h99);
        busy_len(m);
        chk(n + m == SAVE_CYC, "R8 busy not restarted", n + m, SAVE_CYC);
        read_mem(8, 8'h77, "R8 second pulse dropped");
    endtask

    initial begin
        @(negedge clk);
        t_reset_boot();
        t_unknown();
        t_store_read();
        t_recall();
        t_save();
        t_reload();
        t_protect();
        t_busy_ignore();
        $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_bad);
        $finish;
    end

    initial begin
        repeat (20000) @(posedge clk);
        n_chk++;
        n_bad++;
        $display("FAIL watchdog: actual timeout expected completion");
        $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_bad);
        $finish;
    end
endmodule